// File: doc/BRIEF.md
# Interrupt Request Capture Register

This block turns a set of raw interrupt lines into a vector of pending requests. Each line has its own trigger-mode bit. With the bit set, the line is level-sensitive: its pending bit follows the line, one clock later. With the bit clear, the line is edge-sensitive: a rise against the level seen in the previous cycle latches the pending bit, and the bit then stays set until an acknowledge names that line.

An acknowledge is a single-cycle strobe that carries a binary line index. The block always accepts it; there is no back-pressure and no ready signal. A write strobe loads the trigger-mode register. The stored value is the written data ANDed with a constant mask, so a line whose mask bit is 0 stays edge-sensitive. The stored mode is always visible on an output. All inputs are treated as synchronous to `clk`.

Top module: `irq_req_capture`

## Requirements
- R1: While `rst_n` is low, the pending vector, the stored previous levels and the trigger mode are all cleared. A line that is already high when reset is released counts as a rising edge in the first clocked cycle after release.
- R2: For a level line (mode bit 1), `pending_o[i]` one cycle later equals `irq_in[i]`.
- R3: For an edge line (mode bit 0), `irq_in[i]` high in a cycle where the previous cycle's level was low sets `pending_o[i]` in the next cycle.
- R4: On an edge line, an input that stays high or goes low does not change `pending_o[i]`. Only a new rise or an acknowledge can change it.
- R5: `ack_valid` high with `ack_line` = i (binary index, 0 to LINE_CNT-1) clears `pending_o[i]` in the next cycle when line i is an edge line.
- R6: An acknowledge that names a level line has no effect on that line's pending bit. No other line is affected by an acknowledge.
- R7: If an edge line rises in the same cycle that it is acknowledged, its pending bit is set in the next cycle. The rise takes precedence over the acknowledge.
- R8: When `mode_wr_en` is high, the next cycle's `mode_o` equals `mode_wr_data & MODE_WMASK` (default mask 8'hFB, so line 2 is fixed to edge mode). The new mode governs capture from that cycle onward.
- R9: `mode_o` reads back the stored trigger mode and holds its value in every cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| irq_in | input | LINE_CNT | Raw interrupt lines |
| mode_wr_en | input | 1 | Trigger-mode write strobe |
| mode_wr_data | input | LINE_CNT | Trigger-mode write data; bit 1 selects level, bit 0 selects edge |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | $clog2(LINE_CNT) | Binary index of the acknowledged line |
| pending_o | output | LINE_CNT | Pending request vector |
| mode_o | output | LINE_CNT | Stored trigger-mode vector |

## Verification
On every cycle, the assertions check the following against the registered outputs of the previous cycle: level following, edge setting, hold on edge lines, acknowledge clearing, precedence of a rise over an acknowledge, the masked mode write, and that the mode register holds without a write. Some behaviour can be shown only by the bench's scenarios. These are the reset state; the first edge after reset on a line that was held high through reset; and the fact that level lines ignore acknowledges across every combination of mode and input. The bench shows them by sweeping all 256 input patterns under all-edge, all-level and mixed modes, and by acknowledging every line index.

// File: rtl/irq_cap_pkg.sv
`timescale 1ns/1ps
package irq_cap_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_trig_reg.sv
`timescale 1ns/1ps
module irq_trig_reg #(
  parameter int LINE_CNT = 8,
  parameter logic [LINE_CNT-1:0] MODE_WMASK = 8'hFB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [LINE_CNT-1:0] wr_data,
  output logic [LINE_CNT-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_en) begin
      mode_q <= wr_data & MODE_WMASK;
    end
  end
endmodule

// File: rtl/irq_ack_dec.sv
`timescale 1ns/1ps
module irq_ack_dec #(
  parameter int LINE_CNT = 8,
  localparam int IW = $clog2(LINE_CNT)
) (
  input  logic                ack_valid,
  input  logic [IW-1:0]       ack_line,
  output logic [LINE_CNT-1:0] ack_hot
);
  for (genvar i = 0; i < LINE_CNT; i++) begin : g_dec
    assign ack_hot[i] = ack_valid && (ack_line == IW'(i));
  end
endmodule

// File: rtl/irq_line_cell.sv
`timescale 1ns/1ps
module irq_line_cell
  import irq_cap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_e mode,
  input  logic  level_in,
  input  logic  ack_hit,
  output logic  pending,
  output logic  prev_level
);
  logic rise;
  assign rise = level_in && !prev_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      prev_level <= 1'b0;
    end else begin
      prev_level <= level_in;
      unique case (mode)
        TRIG_LEVEL: pending <= level_in;
        default: begin
          if (rise) begin
            pending <= 1'b1;
          end else if (ack_hit) begin
            pending <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_req_capture.sv
`timescale 1ns/1ps
module irq_req_capture
  import irq_cap_pkg::*;
#(
  parameter int LINE_CNT = 8,
  parameter logic [LINE_CNT-1:0] MODE_WMASK = 8'hFB,
  localparam int IW = $clog2(LINE_CNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINE_CNT-1:0] irq_in,
  input  logic                mode_wr_en,
  input  logic [LINE_CNT-1:0] mode_wr_data,
  input  logic                ack_valid,
  input  logic [IW-1:0]       ack_line,
  output logic [LINE_CNT-1:0] pending_o,
  output logic [LINE_CNT-1:0] mode_o
);
  logic [LINE_CNT-1:0] ack_hot;
  logic [LINE_CNT-1:0] prev_q;

  irq_trig_reg #(
    .LINE_CNT  (LINE_CNT),
    .MODE_WMASK(MODE_WMASK)
  ) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mode_wr_en),
    .wr_data(mode_wr_data),
    .mode_q (mode_o)
  );

  irq_ack_dec #(
    .LINE_CNT(LINE_CNT)
  ) u_ack (
    .ack_valid(ack_valid),
    .ack_line (ack_line),
    .ack_hot  (ack_hot)
  );

  for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
    irq_line_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (trig_e'(mode_o[i])),
      .level_in  (irq_in[i]),
      .ack_hit   (ack_hot[i]),
      .pending   (pending_o[i]),
      .prev_level(prev_q[i])
    );
  end
endmodule

// File: rtl/irq_req_capture_chk.sv
`timescale 1ns/1ps
module irq_req_capture_chk #(
  parameter int LINE_CNT = 8,
  parameter logic [LINE_CNT-1:0] MODE_WMASK = 8'hFB,
  localparam int IW = $clog2(LINE_CNT)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [LINE_CNT-1:0] irq_in,
  input logic                mode_wr_en,
  input logic [LINE_CNT-1:0] mode_wr_data,
  input logic                ack_valid,
  input logic [IW-1:0]       ack_line,
  input logic [LINE_CNT-1:0] pending_o,
  input logic [LINE_CNT-1:0] mode_o,
  input logic [LINE_CNT-1:0] prev_q
);
  logic [LINE_CNT-1:0] edge_rise;
  logic [LINE_CNT-1:0] ack_sel;
  logic [LINE_CNT-1:0] edge_hold;

  assign edge_rise = irq_in & ~prev_q & ~mode_o;
  always_comb begin
    ack_sel = '0;
    if (ack_valid) ack_sel[ack_line] = 1'b1;
  end
  assign edge_hold = ~mode_o & ~edge_rise & ~ack_sel;

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending_o & $past(mode_o)) == ($past(irq_in) & $past(mode_o))));

  // R3
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_rise != '0) |=> ((pending_o & $past(edge_rise)) == $past(edge_rise)));

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pending_o ^ $past(pending_o)) & $past(edge_hold)) == '0));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !mode_o[ack_line] && !edge_rise[ack_line])
      |=> !pending_o[$past(ack_line)]);

  // R7
  rise_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && edge_rise[ack_line]) |=> pending_o[$past(ack_line)]);

  // R8
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_en |=> (mode_o == ($past(mode_wr_data) & MODE_WMASK)));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr_en |=> $stable(mode_o));
endmodule

bind irq_req_capture irq_req_capture_chk #(
  .LINE_CNT  (LINE_CNT),
  .MODE_WMASK(MODE_WMASK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_in      (irq_in),
  .mode_wr_en  (mode_wr_en),
  .mode_wr_data(mode_wr_data),
  .ack_valid   (ack_valid),
  .ack_line    (ack_line),
  .pending_o   (pending_o),
  .mode_o      (mode_o),
  .prev_q      (prev_q)
);

// File: tb/irq_req_capture_test.sv
`timescale 1ns/1ps
module irq_req_capture_test;
  localparam logic [7:0] WMASK = 8'hFB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       mode_wr_en = 1'b0;
  logic [7:0] mode_wr_data = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_line = '0;
  logic [7:0] pending_o;
  logic [7:0] mode_o;

  logic [7:0] m_pend = '0, m_prev = '0, m_mode = '0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_req_capture #(.LINE_CNT(8), .MODE_WMASK(WMASK)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .ack_valid(ack_valid), .ack_line(ack_line),
    .pending_o(pending_o), .mode_o(mode_o)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle from a negedge, advance the model, compare at the next negedge.
  task automatic step(input logic [7:0] in, input logic we, input logic [7:0] wd,
                      input logic av, input logic [2:0] al, input string tag);
    logic [7:0] n_pend, n_mode;
    irq_in = in; mode_wr_en = we; mode_wr_data = wd; ack_valid = av; ack_line = al;
    for (int i = 0; i < 8; i++) begin
      if (m_mode[i]) n_pend[i] = in[i];
      else if (in[i] && !m_prev[i]) n_pend[i] = 1'b1;
      else if (av && al == 3'(i)) n_pend[i] = 1'b0;
      else n_pend[i] = m_pend[i];
    end
    n_mode = we ? (wd & WMASK) : m_mode;
    @(posedge clk);
    #1;
    m_pend = n_pend; m_prev = in; m_mode = n_mode;
    mode_wr_en = 1'b0; ack_valid = 1'b0;
    @(negedge clk);
    check(pending_o, m_pend, tag);
    check(mode_o, m_mode, we ? "R8" : "R9");
  endtask

  initial begin
    irq_in = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(pending_o, 8'h00, "R1");
    check(mode_o, 8'h00, "R1");
    // line 0 high through reset: first cycle sees a rise
    step(8'h01, 1'b0, 8'h00, 1'b0, 3'd0, "R1");
    step(8'h00, 1'b0, 8'h00, 1'b1, 3'd0, "R5");

    // masked write: all ones stores FB
    step(8'h00, 1'b1, 8'hFF, 1'b0, 3'd0, "R8");
    for (int v = 0; v < 256; v++) step(8'(v), 1'b0, 8'h00, 1'b0, 3'd0, "R2");
    for (int v = 0; v < 256; v++) step(8'(v), 1'b0, 8'h00, 1'b1, 3'(v), "R6");

    // all edge
    step(8'h00, 1'b1, 8'h00, 1'b0, 3'd0, "R8");
    for (int i = 0; i < 8; i++) step(8'h00, 1'b0, 8'h00, 1'b1, 3'(i), "R5");
    for (int v = 0; v < 256; v++) begin
      step(8'(v), 1'b0, 8'h00, 1'b0, 3'd0, "R3");
      step(8'(v), 1'b0, 8'h00, 1'b0, 3'd0, "R4");
      step(8'h00, 1'b0, 8'h00, 1'b0, 3'd0, "R4");
      for (int i = 0; i < 8; i++) step(8'h00, 1'b0, 8'h00, 1'b1, 3'(i), "R5");
    end

    // rise coincident with acknowledge
    for (int i = 0; i < 8; i++) begin
      step(8'h00, 1'b0, 8'h00, 1'b0, 3'd0, "R7");
      step(8'(1 << i), 1'b0, 8'h00, 1'b1, 3'(i), "R7");
      step(8'h00, 1'b0, 8'h00, 1'b1, 3'(i), "R5");
    end

    // mixed modes
    step(8'h00, 1'b1, 8'hA5, 1'b0, 3'd0, "R8");
    for (int v = 0; v < 256; v++) begin
      step(8'(v), 1'b0, 8'h00, 1'b1, 3'(v), "R6");
      step(8'(v ^ 8'h3C), 1'b0, 8'h00, 1'b1, 3'(v >> 3), "R4");
    end
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'd0, "R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule